// File: doc/BRIEF.md
# Burst Address Counter Unit

This block is the address front end of one port of a synchronous memory. At every rising clock edge it samples an external address together with three active-low controls (clear, strobe and advance) and forms the internal address the memory uses for the access in the cycle that follows. That address comes from one of four sources: zero, the external bus, the counter incremented by one, or the counter value held from the previous cycle.

Only the address matters here. Chip selects, byte enables and read/write are handled elsewhere and have no effect on this block. A clear, a load or an advance takes effect on the next edge, with no idle cycle between them, so a read or a write can go to address zero in the same cycle that the clear becomes visible. Burst accesses load a start address once and then advance one word per cycle.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o is 0. The reset is asynchronous.
- R2: When clr_ni is low at a rising edge, addr_o is 0 after that edge, whatever strobe_ni, adv_ni and addr_i are.
- R3: When clr_ni is high and strobe_ni is low at a rising edge, addr_o equals the addr_i sampled at that edge, whatever adv_ni is.
- R4: When clr_ni and strobe_ni are high and adv_ni is low at a rising edge, addr_o becomes its previous value plus one.
- R5: When clr_ni, strobe_ni and adv_ni are all high at a rising edge, addr_o keeps its value and addr_i is ignored.
- R6: Advancing from the all-ones address (0x7FFF at the default width of 15 bits) gives address 0.
- R7: Every change in addr_o appears one clock edge after the controls that cause it are sampled. No state sits between the input pins and the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. Sampling happens on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External address |
| strobe_ni | input | 1 | Active-low strobe that loads the external address |
| adv_ni | input | 1 | Active-low advance control for the counter |
| clr_ni | input | 1 | Active-low synchronous clear to address 0 |
| addr_o | output | ADDR_W | Internal address for the current access |

## Verification
The assertions assume that every input is settled at each rising edge and holds a known value. They also assume that reset is released away from a clock edge, so that the first edge after reset sees the counter at zero. The bench meets these assumptions by changing inputs only on the falling edge, by releasing reset on a falling edge, and by driving every control to a defined level throughout. Conflicting control combinations are applied on purpose so that the priority order is exercised within those rules.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADV  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } bc_op_e;
endpackage

// File: rtl/bc_decode.sv
module bc_decode
  import bc_pkg::*;
(
  input  logic   strobe_ni,
  input  logic   adv_ni,
  input  logic   clr_ni,
  output bc_op_e op_o
);
  // priority: clear > load > advance > hold
  always_comb begin
    if (!clr_ni)         op_o = OP_CLR;
    else if (!strobe_ni) op_o = OP_LOAD;
    else if (!adv_ni)    op_o = OP_ADV;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/bc_incr.sv
module bc_incr #(
  parameter int unsigned W = 15
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b1;
  // ripple half-adder chain; the final carry is dropped so the count wraps
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign y_o[g]     = a_i[g] ^ carry[g];
    assign carry[g+1] = a_i[g] & carry[g];
  end
  logic unused_carry;
  assign unused_carry = carry[W];
endmodule

// File: rtl/bc_cnt_reg.sv
module bc_cnt_reg
  import bc_pkg::*;
#(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  bc_op_e       op_i,
  input  logic [W-1:0] ext_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;
  always_comb begin
    unique case (op_i)
      OP_CLR:  d = '0;
      OP_LOAD: d = ext_i;
      OP_ADV:  d = inc_i;
      default: d = q_o;
    endcase
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_ni,
  input  logic              adv_ni,
  input  logic              clr_ni,
  output logic [ADDR_W-1:0] addr_o
);
  bc_op_e            op;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_inc;

  bc_decode u_dec (
    .strobe_ni (strobe_ni),
    .adv_ni    (adv_ni),
    .clr_ni    (clr_ni),
    .op_o      (op)
  );

  bc_incr #(.W(ADDR_W)) u_inc (
    .a_i (cnt_q),
    .y_o (cnt_inc)
  );

  bc_cnt_reg #(.W(ADDR_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .ext_i  (addr_i),
    .inc_i  (cnt_inc),
    .q_o    (cnt_q)
  );

  assign addr_o = cnt_q;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strobe_ni,
  input logic              adv_ni,
  input logic              clr_ni,
  input logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (addr_o == '0);
    end
  end

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> addr_o == '0);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !strobe_ni) |=> addr_o == $past(addr_i));

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && strobe_ni && !adv_ni) |=> addr_o == ADDR_W'($past(addr_o) + ONE));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && strobe_ni && adv_ni) |=> $stable(addr_o));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && strobe_ni && !adv_ni && (&addr_o)) |=> addr_o == '0);
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .strobe_ni (strobe_ni),
  .adv_ni    (adv_ni),
  .clr_ni    (clr_ni),
  .addr_o    (addr_o)
);

// File: tb/tb_burst_addr_ctr.sv
`timescale 1ns/1ps
module tb_burst_addr_ctr;
  localparam int unsigned W = 15;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] addr_i = '0;
  logic         strobe_ni = 1'b1, adv_ni = 1'b1, clr_ni = 1'b1;
  logic [W-1:0] addr_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_ctr #(.ADDR_W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .strobe_ni(strobe_ni), .adv_ni(adv_ni), .clr_ni(clr_ni), .addr_o(addr_o)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    n_cmp++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // apply controls on the falling edge, then sample mid-high after the next rising edge
  task automatic cyc(input logic c, input logic s, input logic a, input logic [W-1:0] ad);
    @(negedge clk_i);
    clr_ni = c; strobe_ni = s; adv_ni = a; addr_i = ad;
    @(posedge clk_i);
    #5;
  endtask

  task automatic t_reset();
    #3 check("R1 async reset", '0);
    cyc(1, 0, 1, 15'h1234);
    check("R1 reset held", '0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_load();
    cyc(1, 0, 1, 15'h1A2B);
    check("R3 load", 15'h1A2B);
    cyc(1, 0, 0, 15'h0042);
    check("R3 load over advance", 15'h0042);
  endtask

  task automatic t_advance();
    cyc(1, 1, 0, 15'h7777);
    check("R4 advance 1", 15'h0043);
    cyc(1, 1, 0, 15'h0000);
    check("R4 advance 2", 15'h0044);
    cyc(1, 1, 0, 15'h5555);
    check("R7 one-edge latency", 15'h0045);
  endtask

  task automatic t_hold();
    cyc(1, 1, 1, 15'h3C3C);
    check("R5 hold", 15'h0045);
    cyc(1, 1, 1, 15'h7FFF);
    check("R5 addr_i ignored", 15'h0045);
  endtask

  task automatic t_clear();
    cyc(0, 0, 0, 15'h6000);
    check("R2 clear over load and advance", '0);
    cyc(1, 1, 0, 15'h6000);
    check("R4 advance after clear", 15'h0001);
    cyc(0, 1, 1, 15'h0000);
    check("R2 clear alone", '0);
  endtask

  task automatic t_wrap();
    cyc(1, 0, 1, 15'h7FFE);
    check("R3 load near top", 15'h7FFE);
    cyc(1, 1, 0, 15'h0000);
    check("R6 to top", 15'h7FFF);
    cyc(1, 1, 0, 15'h0000);
    check("R6 wrap", 15'h0000);
    cyc(1, 1, 0, 15'h0000);
    check("R6 after wrap", 15'h0001);
  endtask

  task automatic t_async_reset();
    cyc(1, 0, 1, 15'h2222);
    #2 rst_ni = 1'b0;
    #1 check("R1 async mid-cycle", '0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load();
    t_advance();
    t_hold();
    t_clear();
    t_wrap();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule